// File: doc/BRIEF.md
# Bus Target Device-Select Timing Controller

This block decides, for a target on a shared parallel bus with active-low framing signals, whether and when to claim each transaction by pulling the device-select line low. It watches the frame and initiator-ready strobes to find the start of every address phase. It compares the address with a base/mask window. It then claims either in the first cycle after the address phase (fast) or one cycle later (medium).

Fast claiming is only unsafe when one transaction follows another with no idle cycle between them and a different target may still be driving the select line back high. The block therefore remembers three things: whether the cycle before the address phase was idle, whether this target claimed the previous transaction, and whether the transaction opened with a dual address cycle. It falls back to medium timing only when none of these holds. When a claimed transaction ends, the block drives the select line high for one cycle and then stops driving it. A constant status output reports that the target does this tracking, so initiators may chain transactions freely.

Top module: `devsel_timing_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, devsel_n is 1 and devsel_oe is 0.
- R2: An address phase starts when frame_n is sampled 0 after being sampled 1. If the sample before it had both frame_n and irdy_n at 1 (idle), a hit claims fast: devsel_n is 0 and devsel_oe is 1 in the cycle right after the address cycle.
- R3: If the address phase follows a cycle with frame_n at 1 and irdy_n at 0, and the previous transaction was not claimed by this target, a hit claims at medium timing. In the cycle after the address cycle devsel_oe is 0, and in the cycle after that devsel_n is 0 and devsel_oe is 1.
- R4: In a back-to-back transaction whose predecessor this target claimed, a hit claims fast.
- R5: When cbe_n is 4'b1101 during the first address cycle, the address on ad in the next cycle is decoded and the first is ignored. A hit then claims fast in the cycle after that second address cycle, even back-to-back.
- R6: An address outside the window (ad AND ADDR_MASK differs from ADDR_BASE) never drives devsel_oe.
- R7: While claiming, a sample with frame_n at 1 and irdy_n at 0 marks the final data phase. The next cycle has devsel_n 1 with devsel_oe 1, and the cycle after has devsel_oe 0 unless a new claim starts.
- R8: With FAST_EN set to 0, every claim uses medium timing, whatever came before it.
- R9: fbb_capable is 1 at all times.
- R10: devsel_n is 0 only while devsel_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Active-low transaction frame |
| irdy_n | input | 1 | Active-low initiator ready |
| ad | input | ADDR_W | Multiplexed address/data |
| cbe_n | input | 4 | Command / byte enables, active low |
| devsel_n | output | 1 | Device-select value, active low |
| devsel_oe | output | 1 | Output enable for devsel_n |
| fbb_capable | output | 1 | Back-to-back tracking status bit |

## Verification
The bench sweeps every mix of predecessor (idle gap, own claim, foreign transaction), single or dual address cycle, and hit or miss. It runs each mix on a fast-capable and a medium-only instance, and checks the select line in each of the four cycles after the last address cycle. A design that ignored the back-to-back condition would claim during the turnaround cycle after a foreign transaction. One that forgot its own previous claim would lose a cycle needlessly. One that decoded the first cycle of a dual address would claim the wrong window. A release that skipped the one-cycle high drive, or held it too long, shows up in the last two samples of each hit.

// File: rtl/devsel_timing_pkg.sv
package devsel_timing_pkg;

    localparam logic [3:0] CMD_DUAL_ADDR = 4'b1101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DAC2,
        ST_WAIT,
        ST_CLAIM,
        ST_RELEASE
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e state;
        logic       prev_mine;
    } tgt_regs_t;

endpackage

// File: rtl/devsel_phase_tracker.sv
module devsel_phase_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    output logic addr_start,
    output logic after_idle
);
    typedef struct packed {
        logic frame;
        logic irdy;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d.frame = frame_n;
        hist_d.irdy  = irdy_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '{frame: 1'b1, irdy: 1'b1};
        end else begin
            hist_q <= hist_d;
        end
    end

    // a new address phase: frame goes active after a sample with it inactive
    assign addr_start = !frame_n && hist_q.frame;
    // previous sample was a true idle (both strobes inactive)
    assign after_idle = hist_q.irdy;
endmodule

// File: rtl/devsel_addr_match.sv
module devsel_addr_match #(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] ADDR_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] ADDR_MASK = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0] ad,
    output logic              hit
);
    assign hit = ((ad & ADDR_MASK) == (ADDR_BASE & ADDR_MASK));
endmodule

// File: rtl/devsel_speed_policy.sv
module devsel_speed_policy #(
    parameter bit FAST_EN = 1'b1
) (
    input  logic after_idle,
    input  logic prev_mine,
    input  logic dual_addr,
    output logic fast_ok
);
    generate
        if (FAST_EN) begin : g_fast
            assign fast_ok = after_idle || prev_mine || dual_addr;
        end else begin : g_medium_only
            logic unused_in;
            assign unused_in = after_idle ^ prev_mine ^ dual_addr;
            assign fast_ok   = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/devsel_timing_ctrl.sv
module devsel_timing_ctrl
    import devsel_timing_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] ADDR_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] ADDR_MASK = 32'hFFFF_0000,
    parameter bit                FAST_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [ADDR_W-1:0] ad,
    input  logic [3:0]        cbe_n,
    output logic              devsel_n,
    output logic              devsel_oe,
    output logic              fbb_capable
);
    logic addr_start, after_idle, hit;
    logic fast_first, fast_dual;
    logic is_dual_cmd, final_phase;

    tgt_regs_t r_d, r_q;

    devsel_phase_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .addr_start(addr_start),
        .after_idle(after_idle)
    );

    devsel_addr_match #(
        .ADDR_W   (ADDR_W),
        .ADDR_BASE(ADDR_BASE),
        .ADDR_MASK(ADDR_MASK)
    ) u_match (
        .ad (ad),
        .hit(hit)
    );

    // single-address decision: depends on idle gap and previous owner
    devsel_speed_policy #(.FAST_EN(FAST_EN)) u_pol_single (
        .after_idle(after_idle),
        .prev_mine (r_q.prev_mine),
        .dual_addr (1'b0),
        .fast_ok   (fast_first)
    );

    // second cycle of a dual address: the extra cycle covers turnaround
    devsel_speed_policy #(.FAST_EN(FAST_EN)) u_pol_dual (
        .after_idle(1'b0),
        .prev_mine (1'b0),
        .dual_addr (1'b1),
        .fast_ok   (fast_dual)
    );

    assign is_dual_cmd = (cbe_n == CMD_DUAL_ADDR);
    assign final_phase = frame_n && !irdy_n;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE, ST_RELEASE: begin
                r_d.state = ST_IDLE;
                if (addr_start) begin
                    if (is_dual_cmd) begin
                        r_d.state = ST_DAC2;
                    end else begin
                        r_d.prev_mine = hit;
                        if (hit) begin
                            r_d.state = fast_first ? ST_CLAIM : ST_WAIT;
                        end
                    end
                end
            end
            ST_DAC2: begin
                r_d.prev_mine = hit;
                if (hit) begin
                    r_d.state = fast_dual ? ST_CLAIM : ST_WAIT;
                end else begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_WAIT: begin
                r_d.state = ST_CLAIM;
            end
            ST_CLAIM: begin
                if (final_phase) begin
                    r_d.state = ST_RELEASE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, prev_mine: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign devsel_n    = (r_q.state != ST_CLAIM);
    assign devsel_oe   = (r_q.state == ST_CLAIM) || (r_q.state == ST_RELEASE);
    assign fbb_capable = 1'b1;
endmodule

// File: rtl/devsel_timing_ctrl_chk.sv
module devsel_timing_ctrl_chk #(
    parameter bit FAST_EN = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic frame_n,
    input logic irdy_n,
    input logic devsel_n,
    input logic devsel_oe
);
    // R10: never drive low while the line is not enabled
    a_r10_low_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        devsel_oe || devsel_n);

    // R7: a sampled final data phase while claiming leads to one high-driven cycle
    a_r7_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n && devsel_oe && frame_n && !irdy_n) |=> (devsel_n && devsel_oe));

    // R7: high drive lasts one cycle only
    a_r7_release_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel_oe && devsel_n) |=> (!devsel_oe || !devsel_n));

    // R7: the enable is dropped only after a cycle of driving high
    a_r7_drop_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_oe) |-> $past(devsel_n));

    // R8: a medium-only target always leaves an undriven cycle before claiming
    a_r8_medium_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devsel_n) && (FAST_EN == 1'b0)) |-> !$past(devsel_oe));
endmodule

bind devsel_timing_ctrl devsel_timing_ctrl_chk #(.FAST_EN(FAST_EN)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .devsel_n (devsel_n),
    .devsel_oe(devsel_oe)
);

// File: tb/devsel_timing_ctrl_tb_top.sv
module devsel_timing_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HIT_ADDR  = 32'h4000_1230;
    localparam logic [31:0] MISS_ADDR = 32'h5000_0040;
    localparam logic [3:0]  WR_CMD    = 4'b0111;
    localparam logic [3:0]  DUAL_CMD  = 4'b1101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1;
    logic irdy_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic dn_f, oe_f, fbb_f, dn_s, oe_s, fbb_s;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    devsel_timing_ctrl #(.FAST_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad(ad), .cbe_n(cbe_n), .devsel_n(dn_f), .devsel_oe(oe_f), .fbb_capable(fbb_f)
    );

    devsel_timing_ctrl #(.FAST_EN(1'b0)) dut_slow_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad(ad), .cbe_n(cbe_n), .devsel_n(dn_s), .devsel_oe(oe_s), .fbb_capable(fbb_s)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step(input logic f, input logic i, input logic [31:0] a, input logic [3:0] c);
        frame_n = f; irdy_n = i; ad = a; cbe_n = c;
        @(negedge clk);
    endtask

    // check both instances: claimed_f / claimed_s say whether each is asserting
    task automatic chk_pair(input string rf, input string rs, input string what,
                            input logic claim_f, input logic oe_exp_f,
                            input logic claim_s, input logic oe_exp_s);
        chk(rf, {what, " fast devsel_n"}, dn_f, !claim_f);
        chk(rf, {what, " fast devsel_oe"}, oe_f, oe_exp_f);
        chk(rs, {what, " slow devsel_n"}, dn_s, !claim_s);
        chk(rs, {what, " slow devsel_oe"}, oe_s, oe_exp_s);
    endtask

    function automatic string tag_for(input bit fen, input int kind, input bit dual, input bit hit);
        if (!hit) return "R6";
        if (!fen) return "R8";
        if (dual) return "R5";
        if (kind == 0) return "R2";
        if (kind == 1) return "R4";
        return "R3";
    endfunction

    // kind: 0 idle gap, 1 back-to-back after own claim, 2 back-to-back after foreign
    task automatic run_combo(input int kind, input bit dual, input bit hit);
        logic [31:0] tgt;
        bit fast_f, fast_s;
        string tf, ts;
        tgt = hit ? HIT_ADDR : MISS_ADDR;
        fast_f = (kind != 2) || dual;   // FAST_EN=1 instance
        fast_s = 1'b0;                  // FAST_EN=0 instance
        tf = tag_for(1'b1, kind, dual, hit);
        ts = tag_for(1'b0, kind, dual, hit);
        step(1, 1, 32'h0, 4'hF);
        step(1, 1, 32'h0, 4'hF);
        if (kind != 0) begin
            step(0, 1, (kind == 1) ? HIT_ADDR : MISS_ADDR, WR_CMD);
            step(0, 0, 32'h0, WR_CMD);
            step(0, 0, 32'h0, WR_CMD);
            step(1, 0, 32'h0, WR_CMD);   // final data phase
        end
        if (dual) begin
            // first address cycle carries the opposite decode result: must be ignored
            step(0, 1, hit ? MISS_ADDR : HIT_ADDR, DUAL_CMD);
            step(0, 1, tgt, WR_CMD);
        end else begin
            step(0, 1, tgt, WR_CMD);
        end
        chk_pair(tf, ts, "cycle+1", hit && fast_f, hit && fast_f,
                 hit && fast_s, hit && fast_s);
        step(0, 0, 32'h0, WR_CMD);
        chk_pair(tf, ts, "cycle+2", hit, hit, hit, hit);
        step(1, 0, 32'h0, WR_CMD);
        chk_pair(hit ? "R7" : "R6", hit ? "R7" : "R6", "release", 1'b0, hit, 1'b0, hit);
        step(1, 1, 32'h0, 4'hF);
        chk_pair(hit ? "R7" : "R6", hit ? "R7" : "R6", "after release", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: outputs held idle during reset
        chk_pair("R1", "R1", "in reset", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9", "fbb in reset", fbb_f, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk_pair("R1", "R1", "after reset", 1'b0, 1'b0, 1'b0, 1'b0);
        for (int kind = 0; kind < 3; kind++) begin
            for (int dual = 0; dual < 2; dual++) begin
                for (int hit = 0; hit < 2; hit++) begin
                    run_combo(kind, dual[0], hit[0]);
                end
            end
        end
        // R9: status bit constant on both variants
        chk("R9", "fbb fast", fbb_f, 1'b1);
        chk("R9", "fbb slow", fbb_s, 1'b1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule